// File: doc/BRIEF.md
# Iterative Euclid GCD Engine

This block finds the greatest common divisor of two operands. It uses Euclid's method with one step per clock. Two working registers, `x` and `y`, hold the state. While `y` is nonzero, each cycle takes exactly one of two actions:

- If `x` is greater than `y`, the two registers trade contents.
- Otherwise `y` is reduced by `x`.

When `y` reaches zero, `x` holds the answer.

The same condition, `y` equal to zero, gates both sides of the block. It raises the start-ready output and the result-valid output together. A client offers operands with a start enable. The block takes them only while it is idle. Once the result is shown as valid, the client reads it from the result port. The ordering comparison treats the operands as two's-complement values. It flips the top bit of each and then compares them as unsigned numbers.

Top module: `gcd_iter`

## Requirements
- R1: While `y` is nonzero and `x` is greater than `y` (signed), the next clock edge exchanges `x` and `y`.
- R2: While `y` is nonzero and `x` is less than or equal to `y` (signed), the next clock edge sets `y` to `y - x` and leaves `x` unchanged.
- R3: A start is accepted only while `y` is zero. The accepting edge loads `x` from `start_a` and `y` from `start_b`. If `start_b` is zero, the result `start_a` is valid right after that edge.
- R4: `res_data` always shows `x`. `res_valid` is high exactly when `y` is zero, and the value held there does not change while no start is given. For positive operands, or a zero `start_b`, the result equals the mathematical GCD.
- R5: Reset (active-low `rst_n`) clears `y`, so `start_rdy` and `res_valid` are both high after reset. `x` has no reset value.
- R6: `start_rdy` and `res_valid` are combinational functions of the registered `y`. Both are low for every cycle of an iteration and rise together after the edge on which `y` becomes zero.
- R7: The comparison is signed. For example, with `x = 32'h8000_0000` and `y = 32'h4000_0000`, the block subtracts instead of swapping, and the iteration never ends.
- R8: `start_en` has no effect while `start_rdy` is low. Operands offered during an iteration do not change its result or its length.
- R9: In any cycle, at most one of load, swap or subtract takes effect. A swap or subtract never happens while the block is ready for a start.
- R10: Operands `start_a = 6` and `start_b = 15` take exactly five steps (subtract, subtract, swap, subtract, subtract) and give 3. Operands 15 and 6 take six steps, because a leading swap comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of `y` |
| start_a | input | WIDTH | First operand, loaded into `x` |
| start_b | input | WIDTH | Second operand, loaded into `y` |
| start_en | input | 1 | Start request; acted on only with `start_rdy` |
| start_rdy | output | 1 | High when a start will be accepted (`y` is zero) |
| res_data | output | WIDTH | Result, the contents of `x` |
| res_valid | output | 1 | High when `res_data` holds a finished result (`y` is zero) |

## Verification
The bench goes after exact step counts:

- The pair 6/15 against 15/6 shows whether a design orders swap and subtract correctly. A design that does not would take a different number of cycles or return the wrong value.
- Equal operands and a zero second operand test the boundary of the comparison and the zero-step path. A design that got these wrong would hang or report a stale value.

The bench also offers new operands in the middle of an iteration. A design that ignores the ready guard would restart and return the wrong GCD.

A pair with the top bit set exposes an unsigned comparison. Such a design would finish in three steps, where the signed design keeps iterating.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_SWAP = 2'd2,
      ACT_SUB  = 2'd3
   } gcd_act_e;

   function automatic logic act_is_step(input gcd_act_e act);
      return (act == ACT_SWAP) || (act == ACT_SUB);
   endfunction

endpackage

// File: rtl/gcd_le_cmp.sv
module gcd_le_cmp #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   output logic             lhs_le_rhs
);
   localparam logic [WIDTH-1:0] SIGN_MASK = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] lhs_k;
   logic [WIDTH-1:0] rhs_k;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gcd_le_cmp: WIDTH must be at least 2");
      end
      if (SIGNED_CMP) begin : g_signed
         // flipping the sign bit maps two's complement order onto unsigned order
         assign lhs_k = lhs ^ SIGN_MASK;
         assign rhs_k = rhs ^ SIGN_MASK;
      end else begin : g_unsigned
         assign lhs_k = lhs;
         assign rhs_k = rhs;
      end
   endgenerate

   assign lhs_le_rhs = (lhs_k <= rhs_k);

endmodule

// File: rtl/gcd_act_sel.sv
module gcd_act_sel
   import gcd_pkg::*;
(
   input  logic     start_en,
   input  logic     y_zero,
   input  logic     x_le_y,
   output gcd_act_e act
);
   always_comb begin
      if (y_zero) begin
         act = start_en ? ACT_LOAD : ACT_IDLE;
      end else if (x_le_y) begin
         act = ACT_SUB;
      end else begin
         act = ACT_SWAP;
      end
   end
endmodule

// File: rtl/gcd_state_regs.sv
module gcd_state_regs
   import gcd_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gcd_act_e         act,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] x_q,
   output logic [WIDTH-1:0] y_q
);
   logic [WIDTH-1:0] x_d;
   logic [WIDTH-1:0] y_d;

   always_comb begin
      x_d = x_q;
      y_d = y_q;
      unique case (act)
         ACT_LOAD: begin
            x_d = a_in;
            y_d = b_in;
         end
         ACT_SWAP: begin
            x_d = y_q;
            y_d = x_q;
         end
         ACT_SUB: begin
            y_d = y_q - x_q;
         end
         default: ;
      endcase
   end

   // x deliberately carries no reset
   always_ff @(posedge clk) begin
      x_q <= x_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y_q <= '0;
      else        y_q <= y_d;
   end

   // R1
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_SWAP) |=> (x_q == $past(y_q)) && (y_q == $past(x_q)));

   // R2
   sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_SUB) |=> (y_q == $past(y_q) - $past(x_q)) && $stable(x_q));

   // R3
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOAD) |=> (x_q == $past(a_in)) && (y_q == $past(b_in)));

endmodule

// File: rtl/gcd_iter.sv
module gcd_iter
   import gcd_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] start_a,
   input  logic [WIDTH-1:0] start_b,
   input  logic             start_en,
   output logic             start_rdy,
   output logic [WIDTH-1:0] res_data,
   output logic             res_valid
);
   localparam logic [WIDTH-1:0] ZERO_W = '0;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gcd_iter: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] x_q;
   logic [WIDTH-1:0] y_q;
   logic             y_zero;
   logic             x_le_y;
   gcd_act_e         act;

   assign y_zero = (y_q == ZERO_W);

   gcd_le_cmp #(
      .WIDTH      (WIDTH),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_cmp (
      .lhs        (x_q),
      .rhs        (y_q),
      .lhs_le_rhs (x_le_y)
   );

   gcd_act_sel u_sel (
      .start_en (start_en),
      .y_zero   (y_zero),
      .x_le_y   (x_le_y),
      .act      (act)
   );

   gcd_state_regs #(
      .WIDTH (WIDTH)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .a_in  (start_a),
      .b_in  (start_b),
      .x_q   (x_q),
      .y_q   (y_q)
   );

   assign start_rdy = y_zero;
   assign res_valid = y_zero;
   assign res_data  = x_q;

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !start_en) |=> res_valid && $stable(res_data));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_rdy && start_en) |-> (act != ACT_LOAD));

   // R9
   step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_is_step(act) |-> !start_rdy);

   generate
      if (SIGNED_CMP) begin : g_cmp_chk
         // R7
         signed_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !y_zero |-> (x_le_y == ($signed(x_q) <= $signed(y_q))));
      end
   endgenerate

endmodule

// File: tb/gcd_iter_tb.sv
module gcd_iter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 32;
   localparam int WDOG_LIMIT = 190000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] start_a = '0;
   logic [W-1:0] start_b = '0;
   logic         start_en = 1'b0;
   logic         start_rdy;
   logic [W-1:0] res_data;
   logic         res_valid;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gcd_iter #(.WIDTH(W), .SIGNED_CMP(1'b1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_a   (start_a),
      .start_b   (start_b),
      .start_en  (start_en),
      .start_rdy (start_rdy),
      .res_data  (res_data),
      .res_valid (res_valid)
   );

   function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] p = a;
      logic [W-1:0] q = b;
      logic [W-1:0] t;
      while (q != 0) begin
         t = p % q;
         p = q;
         q = t;
      end
      return p;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      start_en = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Issue a start and wait for the result; with junk set, offer other
   // operands on every busy cycle.
   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit junk,
                      input int max_cyc, output logic [W-1:0] res, output int cyc,
                      output bit rdy_low_ok);
      start_a  = a;
      start_b  = b;
      start_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_en   = junk;
      start_a    = 32'd99;
      start_b    = 32'd7;
      cyc        = 0;
      rdy_low_ok = 1'b1;
      while (!res_valid && cyc < max_cyc) begin
         if (start_rdy) rdy_low_ok = 1'b0;
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      start_en = 1'b0;
      res      = res_data;
   endtask

   initial begin : watchdog
      int n = 0;
      while (!done) begin
         @(posedge clk);
         n++;
         if (n > WDOG_LIMIT && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", n, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin : main
      logic [W-1:0] res;
      int           cyc;
      bit           rl;
      void'($urandom(32'd20240611));

      do_reset();
      // R5: idle after reset
      check(start_rdy === 1'b1, "R5 rdy", start_rdy, 1);
      check(res_valid === 1'b1, "R5 valid", res_valid, 1);

      // R10 / R1 / R2: 6,15 -> 3 in five steps
      run(32'd6, 32'd15, 1'b0, 100, res, cyc, rl);
      check(res == 32'd3, "R10 result", res, 3);
      check(cyc == 5, "R10 steps", cyc, 5);
      check(rl, "R6 busy low", rl, 1);

      // R1: leading swap adds one step
      run(32'd15, 32'd6, 1'b0, 100, res, cyc, rl);
      check(res == 32'd3, "R1 result", res, 3);
      check(cyc == 6, "R1 steps", cyc, 6);

      // R3: zero second operand finishes at once
      run(32'd42, 32'd0, 1'b0, 100, res, cyc, rl);
      check(res == 32'd42 && cyc == 0, "R3 b zero", res, 42);
      run(32'd0, 32'd0, 1'b0, 100, res, cyc, rl);
      check(res == 32'd0 && cyc == 0, "R3 both zero", res, 0);

      // R2: equal operands, one subtract
      run(32'd7, 32'd7, 1'b0, 100, res, cyc, rl);
      check(res == 32'd7 && cyc == 1, "R2 equal", cyc, 1);

      // R8: offers during iteration are ignored
      run(32'd6, 32'd15, 1'b1, 100, res, cyc, rl);
      check(res == 32'd3, "R8 result", res, 3);
      check(cyc == 5, "R8 steps", cyc, 5);

      // R4: result held while idle
      repeat (4) @(negedge clk);
      check(res_valid && res_data == 32'd3, "R4 hold", res_data, 3);

      // R7: signed ordering keeps this pair iterating
      run(32'h8000_0000, 32'h4000_0000, 1'b0, 40, res, cyc, rl);
      check(res_valid === 1'b0, "R7 signed", res_valid, 0);
      do_reset();
      check(start_rdy === 1'b1, "R5 re-reset", start_rdy, 1);

      // R4: random positive pairs against the reference
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] ra = ($urandom % 1000) + 1;
         logic [W-1:0] rb = (i % 8 == 0) ? 32'd0 : ($urandom % 1000) + 1;
         run(ra, rb, 1'b0, 4000, res, cyc, rl);
         check(res_valid && res == ref_gcd(ra, rb), "R4 random", res, ref_gcd(ra, rb));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule